// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Command Engine

This block holds the digital state of a four-channel digital-to-analog converter. Each channel keeps a range setting and an output code, and both are double-buffered. Holding copies take host writes. Active copies drive the converter. A host gives a one-cycle strobe together with an 8-bit command byte and a 16-bit data word. The block then does one of four things: it writes a holding buffer, it promotes holding contents to the active buffers, it does both, or it reads a buffer back.

Every command also returns a 16-bit readback word. For ordinary commands this word is the buffer named by a pointer that the previous command left behind. For the explicit read commands it is the buffer the command names. Each channel's active range and the upper 12 bits of its active code leave the block as plain digital buses.

Top module: `qdac_cmd_engine`

## Requirements
- R1: Reset clears every holding and active range and code to zero. It also sets `rb_word` to zero, `done` to 0 and the readback pointer to the active range of channel A.
- R2: Command byte bits 7:4 carry the operation and bits 3:0 carry the address. Address 0, 2, 4 or 6 selects channel A, B, C or D. Address 15 applies writes and updates to all four channels and uses channel A for readback and for the pointer.
- R3: Operation 2 writes the holding range and operation 3 writes the holding code. Neither changes any active output.
- R4: Operation 4 copies both holding buffers of the addressed channel into its active buffers. Operation 5 does this for all four channels.
- R5: Operations 6 and 7 write the holding range or code and then update the addressed channel. Operations 8 and 9 do the same write and then update all channels. In each case the active buffer receives the newly written value.
- R6: For every command other than a read, `rb_word` carries the buffer named by the pointer left by the previous command, taken before the command changes anything. The pointer left behind is:
  - holding range of n for operations 2 and 6;
  - holding code of n for operation 3;
  - active range of n for operations 4, 8 and 15;
  - active code of n for operations 5, 7 and 9.
- R7: Operations 10, 11, 12 and 13 return the holding range, holding code, active range and active code of n in the same transaction, and point the pointer at that buffer.
- R8: The range comes from data bits 3:0, and readback returns it zero-extended. Values 0 to 5 are legal. A range write with a value above 5 is dropped entirely.
- R9: A command is rejected if its operation is 0, 1 or 14, if its address is not in {0,2,4,6,15}, or if it carries an illegal range. A rejected command changes no buffer and leaves the pointer alone, but still returns the buffer at the current pointer.
- R10: `rb_word` and a one-cycle `done` pulse appear on the cycle after the strobe. `rb_word` holds its value until the next command.
- R11: Codes are stored as 16 bits. The active code bus carries bits 15:4 of each channel's active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Operation (7:4) and address (3:0) |
| data_in | input | 16 | Data word for range or code writes |
| rb_word | output | 16 | Readback word of the last command |
| done | output | 1 | Pulses one cycle after a strobe |
| act_span | output | 16 | Active ranges, 4 bits per channel, channel A in bits 3:0 |
| act_code | output | 48 | Active codes (upper 12 bits), channel A in bits 11:0 |

## Verification
A wrong holding buffer stays invisible on the active buses until an update promotes it. It can show up earlier through readback, one cycle after a read command or after any command issued while the pointer names that buffer. A wrong pointer shows up on the readback word of the very next command. Wrong active state or a bad update mask shows on `act_span` or `act_code` one cycle after the strobe. Random command streams therefore compare every readback word and both active buses after every command against a bench model.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    BK_HSPAN = 2'd0,
    BK_HCODE = 2'd1,
    BK_ASPAN = 2'd2,
    BK_ACODE = 2'd3
  } buf_kind_e;

  localparam logic [3:0] OP_WSPAN     = 4'h2;
  localparam logic [3:0] OP_WCODE     = 4'h3;
  localparam logic [3:0] OP_UPD_ONE   = 4'h4;
  localparam logic [3:0] OP_UPD_ALL   = 4'h5;
  localparam logic [3:0] OP_WSPAN_U1  = 4'h6;
  localparam logic [3:0] OP_WCODE_U1  = 4'h7;
  localparam logic [3:0] OP_WSPAN_UA  = 4'h8;
  localparam logic [3:0] OP_WCODE_UA  = 4'h9;
  localparam logic [3:0] OP_RD_HSPAN  = 4'hA;
  localparam logic [3:0] OP_RD_HCODE  = 4'hB;
  localparam logic [3:0] OP_RD_ASPAN  = 4'hC;
  localparam logic [3:0] OP_RD_ACODE  = 4'hD;
  localparam logic [3:0] OP_NOP       = 4'hF;

  localparam logic [3:0] ADDR_ALL     = 4'hF;
  localparam logic [3:0] SPAN_MAX     = 4'd5;
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int CHW = 2
) (
  input  logic [7:0]     cmd,
  input  logic [3:0]     span_nib,
  output logic           accept,
  output logic           is_read,
  output logic           is_all,
  output logic [CHW-1:0] ch,
  output buf_kind_e      nxt_kind,
  output logic           wr_span,
  output logic           wr_code,
  output logic           upd_one,
  output logic           upd_all
);
  logic [3:0] op;
  logic [3:0] adr;
  logic       op_known;
  logic       adr_ok;
  logic       span_ok;

  assign op  = cmd[7:4];
  assign adr = cmd[3:0];

  always_comb begin
    op_known = 1'b1;
    nxt_kind = BK_ASPAN;
    wr_span  = 1'b0;
    wr_code  = 1'b0;
    upd_one  = 1'b0;
    upd_all  = 1'b0;
    is_read  = 1'b0;
    case (op)
      OP_WSPAN:    begin wr_span = 1'b1; nxt_kind = BK_HSPAN; end
      OP_WCODE:    begin wr_code = 1'b1; nxt_kind = BK_HCODE; end
      OP_UPD_ONE:  begin upd_one = 1'b1; nxt_kind = BK_ASPAN; end
      OP_UPD_ALL:  begin upd_all = 1'b1; nxt_kind = BK_ACODE; end
      OP_WSPAN_U1: begin wr_span = 1'b1; upd_one = 1'b1; nxt_kind = BK_HSPAN; end
      OP_WCODE_U1: begin wr_code = 1'b1; upd_one = 1'b1; nxt_kind = BK_ACODE; end
      OP_WSPAN_UA: begin wr_span = 1'b1; upd_all = 1'b1; nxt_kind = BK_ASPAN; end
      OP_WCODE_UA: begin wr_code = 1'b1; upd_all = 1'b1; nxt_kind = BK_ACODE; end
      OP_RD_HSPAN: begin is_read = 1'b1; nxt_kind = BK_HSPAN; end
      OP_RD_HCODE: begin is_read = 1'b1; nxt_kind = BK_HCODE; end
      OP_RD_ASPAN: begin is_read = 1'b1; nxt_kind = BK_ASPAN; end
      OP_RD_ACODE: begin is_read = 1'b1; nxt_kind = BK_ACODE; end
      OP_NOP:      nxt_kind = BK_ASPAN;
      default:     op_known = 1'b0;
    endcase
  end

  // Legal channel addresses: 0,2,4,6 (bit 0 low, bit 3 low) or the broadcast code
  assign is_all  = (adr == ADDR_ALL);
  assign adr_ok  = is_all || (adr[3] == 1'b0 && adr[0] == 1'b0);
  assign ch      = is_all ? '0 : CHW'(adr[2:1]);
  assign span_ok = (span_nib <= SPAN_MAX);
  assign accept  = op_known && adr_ok && (!wr_span || span_ok);
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
#(
  parameter int SPW = 4,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_span_en,
  input  logic           wr_code_en,
  input  logic           upd_en,
  input  logic [SPW-1:0] span_d,
  input  logic [CW-1:0]  code_d,
  output logic [SPW-1:0] h_span,
  output logic [CW-1:0]  h_code,
  output logic [SPW-1:0] a_span,
  output logic [CW-1:0]  a_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h_span <= '0;
      h_code <= '0;
      a_span <= '0;
      a_code <= '0;
    end else begin
      if (wr_span_en) h_span <= span_d;
      if (wr_code_en) h_code <= code_d;
      if (upd_en) begin
        a_span <= wr_span_en ? span_d : h_span;
        a_code <= wr_code_en ? code_d : h_code;
      end
    end
  end

  // R8
  span_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (h_span <= SPW'(SPAN_MAX)) && (a_span <= SPW'(SPAN_MAX)));

  // R5
  upd_takes_new_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && wr_code_en) |=> (a_code == h_code));
endmodule

// File: rtl/qdac_rbsel.sv
module qdac_rbsel
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int SPW = 4,
  parameter int CW  = 16
) (
  input  logic [NCH-1:0][SPW-1:0] h_span,
  input  logic [NCH-1:0][CW-1:0]  h_code,
  input  logic [NCH-1:0][SPW-1:0] a_span,
  input  logic [NCH-1:0][CW-1:0]  a_code,
  input  buf_kind_e               kind,
  input  logic [CHW-1:0]          ch,
  output logic [CW-1:0]           word
);
  always_comb begin
    case (kind)
      BK_HSPAN: word = CW'(h_span[ch]);
      BK_HCODE: word = h_code[ch];
      BK_ASPAN: word = CW'(a_span[ch]);
      default:  word = a_code[ch];
    endcase
  end
endmodule

// File: rtl/qdac_cmd_engine.sv
module qdac_cmd_engine
  import qdac_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SPW  = 4,
  parameter int CW   = 16,
  parameter int OUTW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_stb,
  input  logic [7:0]          cmd_byte,
  input  logic [CW-1:0]       data_in,
  output logic [CW-1:0]       rb_word,
  output logic                done,
  output logic [NCH*SPW-1:0]  act_span,
  output logic [NCH*OUTW-1:0] act_code
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                     accept, is_read, is_all;
  logic                     wr_span, wr_code, upd_one, upd_all;
  logic [CHW-1:0]           ch;
  buf_kind_e                nxt_kind;
  buf_kind_e                ptr_kind;
  logic [CHW-1:0]           ptr_ch;
  logic [NCH-1:0][SPW-1:0]  h_span, a_span;
  logic [NCH-1:0][CW-1:0]   h_code, a_code;
  logic [CW-1:0]            ptr_word, read_word;
  logic                     stb_ok;

  assign stb_ok = cmd_stb && accept;

  qdac_decode #(.CHW(CHW)) u_dec (
    .cmd(cmd_byte), .span_nib(data_in[3:0]), .accept(accept),
    .is_read(is_read), .is_all(is_all), .ch(ch), .nxt_kind(nxt_kind),
    .wr_span(wr_span), .wr_code(wr_code), .upd_one(upd_one), .upd_all(upd_all)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = is_all || (ch == CHW'(i));
    qdac_chan #(.SPW(SPW), .CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_span_en(stb_ok && wr_span && sel),
      .wr_code_en(stb_ok && wr_code && sel),
      .upd_en(stb_ok && (upd_all || (upd_one && sel))),
      .span_d(data_in[SPW-1:0]), .code_d(data_in),
      .h_span(h_span[i]), .h_code(h_code[i]),
      .a_span(a_span[i]), .a_code(a_code[i])
    );
    assign act_span[i*SPW +: SPW]   = a_span[i];
    assign act_code[i*OUTW +: OUTW] = a_code[i][CW-1 -: OUTW];
  end

  qdac_rbsel #(.NCH(NCH), .CHW(CHW), .SPW(SPW), .CW(CW)) u_rb_ptr (
    .h_span(h_span), .h_code(h_code), .a_span(a_span), .a_code(a_code),
    .kind(ptr_kind), .ch(ptr_ch), .word(ptr_word)
  );

  qdac_rbsel #(.NCH(NCH), .CHW(CHW), .SPW(SPW), .CW(CW)) u_rb_rd (
    .h_span(h_span), .h_code(h_code), .a_span(a_span), .a_code(a_code),
    .kind(nxt_kind), .ch(ch), .word(read_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_kind <= BK_ASPAN;
      ptr_ch   <= '0;
      rb_word  <= '0;
      done     <= 1'b0;
    end else begin
      done <= cmd_stb;
      if (cmd_stb) begin
        rb_word <= (accept && is_read) ? read_word : ptr_word;
        if (accept) begin
          ptr_kind <= nxt_kind;
          ptr_ch   <= ch;
        end
      end
    end
  end

  // R10
  done_follows_stb_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> done);

  // R10
  done_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_stb));

  // R10
  rb_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |=> $stable(rb_word));

  // R3
  hold_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && (cmd_byte[7:4] == OP_WSPAN || cmd_byte[7:4] == OP_WCODE))
      |=> ($stable(act_span) && $stable(act_code)));

  // R9
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !accept) |=> ($stable(act_span) && $stable(act_code)));
endmodule

// File: tb/sim_qdac_cmd_engine.sv
module sim_qdac_cmd_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_stb;
  logic [7:0]  cmd_byte;
  logic [15:0] data_in;
  logic [15:0] rb_word;
  logic        done;
  logic [15:0] act_span;
  logic [47:0] act_code;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0]  m_hs [4];
  logic [15:0] m_hc [4];
  logic [3:0]  m_as [4];
  logic [15:0] m_ac [4];
  int          m_pk;
  int          m_pc;

  always #2 clk = ~clk;

  qdac_cmd_engine u0 (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .data_in(data_in), .rb_word(rb_word), .done(done),
    .act_span(act_span), .act_code(act_code)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] peek(int k, int c);
    case (k)
      0: return {12'd0, m_hs[c]};
      1: return m_hc[c];
      2: return {12'd0, m_as[c]};
      default: return m_ac[c];
    endcase
  endfunction

  // Reference behaviour built from R2..R9; returns expected readback word
  function automatic logic [15:0] model(int op, int adr, logic [15:0] d);
    bit all, aok, known, ws, wc, u1, ua, rd;
    int c, k;
    logic [15:0] r;
    all = (adr == 15);
    aok = all || adr inside {0, 2, 4, 6};
    c = all ? 0 : adr / 2;
    known = 1; ws = 0; wc = 0; u1 = 0; ua = 0; rd = 0; k = 2;
    case (op)
      2: begin ws = 1; k = 0; end
      3: begin wc = 1; k = 1; end
      4: begin u1 = 1; k = 2; end
      5: begin ua = 1; k = 3; end
      6: begin ws = 1; u1 = 1; k = 0; end
      7: begin wc = 1; u1 = 1; k = 3; end
      8: begin ws = 1; ua = 1; k = 2; end
      9: begin wc = 1; ua = 1; k = 3; end
      10, 11, 12, 13: begin rd = 1; k = op - 10; end
      15: k = 2;
      default: known = 0;
    endcase
    if (!(known && aok && (!ws || d[3:0] <= 5))) return peek(m_pk, m_pc);
    r = rd ? peek(k, c) : peek(m_pk, m_pc);
    for (int i = 0; i < 4; i++) begin
      bit sel;
      sel = all || (i == c);
      if (ws && sel) m_hs[i] = d[3:0];
      if (wc && sel) m_hc[i] = d;
      if (ua || (u1 && sel)) begin
        m_as[i] = m_hs[i];
        m_ac[i] = m_hc[i];
      end
    end
    m_pk = k;
    m_pc = c;
    return r;
  endfunction

  task automatic check_act(string req);
    for (int i = 0; i < 4; i++) begin
      check({req, " act_span"}, act_span[i*4 +: 4], m_as[i]);
      // R11: upper 12 code bits reach the output
      check({req, " R11 act_code"}, act_code[i*12 +: 12], m_ac[i][15:4]);
    end
  endtask

  task automatic issue(string req, int op, int adr, logic [15:0] d);
    logic [15:0] exp;
    exp = model(op, adr, d);
    cmd_byte = {op[3:0], adr[3:0]};
    data_in  = d;
    cmd_stb  = 1'b1;
    @(negedge clk);
    cmd_stb  = 1'b0;
    check({req, " R10 done"}, done, 1'b1);
    check({req, " R6/R7 rb_word"}, rb_word, exp);
    check_act(req);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] hold;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) begin
      m_hs[i] = 0; m_hc[i] = 0; m_as[i] = 0; m_ac[i] = 0;
    end
    m_pk = 2; m_pc = 0;
    rst = 1'b1; cmd_stb = 1'b0; cmd_byte = 8'h00; data_in = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rb_word", rb_word, 16'h0);
    check("R1 done", done, 1'b0);
    check("R1 act_span", act_span, 16'h0);
    check("R1 act_code", act_code, 48'h0);

    // R1 pointer starts on active range of A; R3 holding write
    issue("R3 wcode B", 3, 2, 16'h1234);
    issue("R3 wspan B", 2, 2, 16'h0003);
    issue("R4 upd B", 4, 2, 16'hFFFF);
    issue("R11 rd acode B", 13, 2, 16'h0);
    issue("R4 upd all", 5, 0, 16'h0);
    issue("R5 wcode+upd D", 7, 6, 16'hBEEF);
    issue("R5 wspan+upd C", 6, 4, 16'h0005);
    issue("R5 wspan all-upd", 8, 0, 16'h0004);
    issue("R5 wcode all-upd", 9, 15, 16'h8001);
    issue("R2 broadcast span", 2, 15, 16'h0002);
    issue("R7 rd hspan D", 10, 6, 16'h0);
    issue("R7 rd hcode A", 11, 0, 16'h0);
    issue("R7 rd aspan all", 12, 15, 16'h0);
    // R8 illegal range drops whole command (update part too)
    issue("R8 bad span", 6, 2, 16'h0007);
    issue("R8 bad span upper", 8, 0, 16'h000F);
    issue("R8 high bits ignored", 2, 0, 16'hF001);
    // R9 reserved op/addr
    issue("R9 op0", 0, 0, 16'h1111);
    issue("R9 opE", 14, 2, 16'h2222);
    issue("R9 addr1", 3, 1, 16'h3333);
    issue("R9 addr8", 5, 8, 16'h0);
    issue("R6 nop", 15, 4, 16'h0);
    issue("R6 after nop", 15, 0, 16'h0);
    // R10 rb_word holds, done drops
    hold = rb_word;
    @(negedge clk);
    check("R10 done low", done, 1'b0);
    check("R10 rb hold", rb_word, hold);

    for (int n = 0; n < 3000; n++) begin
      int op, adr, pick;
      logic [15:0] d;
      op = $urandom_range(0, 15);
      pick = $urandom_range(0, 9);
      adr = (pick < 8) ? 2 * (pick % 4) : ((pick == 8) ? 15 : $urandom_range(0, 15));
      d = 16'($urandom);
      if (op inside {2, 6, 8}) d = {12'd0, 4'($urandom_range(0, 7))};
      issue("R6 random", op, adr, d);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule